// File: doc/BRIEF.md
# Dual-Compare Timer Status Register

This block is the control and status register of a small 8-bit up-counting timer. The counter and its two compare registers (channel A and channel B) are built in. Three hardware conditions each latch a sticky flag in the register: the counter reaching compare value A, the counter reaching compare value B, and the counter wrapping past its top value. Software cannot set these flags. A flag is cleared only by a deliberate two-step handshake: software first reads the register while the flag is 1, and then writes a 0 to that flag's bit. The low four bits are an output-select field. It decides how a single compare output pin reacts when either compare event occurs.

The CPU reaches four byte registers through one port with read and write strobes and a 2-bit address: 0 is the status/control register, 1 the counter, 2 compare A and 3 compare B. External event inputs can also raise each flag, in addition to the internal counter logic. While the low-power mode input is high, the status/control register is held at its reset value 0x10. Flags, output select and the clear handshake all return to idle, and register writes to it are ignored.

Top module: `dct_timer_csr`

## Requirements
- R1: After reset, address 0 reads 0x10, the counter (address 1) reads 0x00, both compare registers (addresses 2 and 3) read 0xFF, and the compare pin is 0.
- R2: While the low-power input is high, address 0 reads 0x10 and writes to it are ignored. From the next clock edge the flags, the output select and all arm states are 0.
- R3: The overflow flag (bit 5 of address 0) is set at the clock edge where a count tick moves the counter from 0xFF to 0x00. The external overflow input, when high for a cycle, also sets it.
- R4: Flag A (bit 6) is set at the edge where a count tick makes the counter equal compare A. Flag B (bit 7) is set likewise with compare B. The external event inputs also set the matching flag.
- R5: Writing 1 to bits 7, 6 or 5 never sets a flag. Bit 4 reads 1 at all times and ignores writes.
- R6: A write of 0 to a flag bit clears that flag only if a read of address 0 returned it as 1 after the previous write to address 0. Otherwise the flag keeps its value.
- R7: Every write to address 0 disarms all three flags, including writes that clear nothing. A second clearing write therefore needs a new read first.
- R8: If a set event and a valid clearing write hit the same flag in one cycle, the flag remains 1.
- R9: Bits 3..0 of address 0 read back the value last written, from the edge after the write.
- R10: Output select bits 1..0 give the action on a channel A event and bits 3..2 the action on a channel B event: 00 hold, 01 drive low, 10 drive high, 11 toggle. The pin changes on the same edge as the flag. A B event with a non-hold action takes precedence over a simultaneous A event. No pin action happens in low-power mode.
- R11: Addresses 1, 2 and 3 can be read and written. A counter write in the same cycle as a count tick loads the written value, and that tick raises no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lp_mode_i | input | 1 | Low-power mode, holds the status/control register at 0x10 |
| tick_i | input | 1 | Count enable for one cycle |
| rd_i | input | 1 | Register read strobe |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select: 0 status/control, 1 counter, 2 compare A, 3 compare B |
| wdata_i | input | 8 | Write data |
| ext_cma_i | input | 1 | External compare A event |
| ext_cmb_i | input | 1 | External compare B event |
| ext_ovf_i | input | 1 | External overflow event |
| rdata_o | output | 8 | Read data of the addressed register (combinational) |
| cmp_pin_o | output | 1 | Compare output pin |

## Verification
A hardware set event and a software clearing write can land on the same flag in the same cycle, and that collision is the case that matters most. The bench provokes it on purpose: it arms flag A with a read, then issues the clearing write in the very cycle that an external A event is pulsed. It then expects the flag to read 1. The random phase pulses event inputs and count ticks while reads and writes go on, and every cycle is compared against a bench model in which set beats clear. The pin's B-over-A precedence is exercised the same way, by raising both events in one cycle.

// File: rtl/dct_pkg.sv
package dct_pkg;
  localparam int unsigned DW      = 8;
  localparam int unsigned NFLAG   = 3;
  localparam int unsigned FLG_LSB = 5;
  localparam int unsigned OS_W    = 4;

  localparam logic [DW-1:0] CSR_RESET = 8'h10;

  typedef enum logic [1:0] {
    ADDR_CSR  = 2'd0,
    ADDR_CNT  = 2'd1,
    ADDR_CMPA = 2'd2,
    ADDR_CMPB = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    PIN_HOLD   = 2'd0,
    PIN_LOW    = 2'd1,
    PIN_HIGH   = 2'd2,
    PIN_TOGGLE = 2'd3
  } pin_act_e;

  // flag index order inside the flag vector
  localparam int unsigned FI_OVF = 0;
  localparam int unsigned FI_CMA = 1;
  localparam int unsigned FI_CMB = 2;
endpackage

// File: rtl/dct_rst_sync.sv
module dct_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/dct_count_unit.sv
module dct_count_unit #(
  parameter int unsigned      W        = 8,
  parameter logic [W-1:0]     CMP_INIT = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         wr_cnt_i,
  input  logic         wr_cmpa_i,
  input  logic         wr_cmpb_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cmpa_o,
  output logic [W-1:0] cmpb_o,
  output logic         hit_ovf_o,
  output logic         hit_a_o,
  output logic         hit_b_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] cnt_q, cnt_d, cnt_inc;
  logic [W-1:0] cmpa_q, cmpb_q;
  logic         cnt_en, advance;

  always_comb begin
    cnt_inc = cnt_q + ONE;
    advance = tick_i & ~wr_cnt_i;
    cnt_en  = wr_cnt_i | advance;
    if (wr_cnt_i) cnt_d = wdata_i;
    else          cnt_d = cnt_inc;
  end

  always_comb begin
    hit_ovf_o = advance & (cnt_q == TOP);
    hit_a_o   = advance & (cnt_inc == cmpa_q);
    hit_b_o   = advance & (cnt_inc == cmpb_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cmpa_q <= CMP_INIT;
    else if (wr_cmpa_i) cmpa_q <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cmpb_q <= CMP_INIT;
    else if (wr_cmpb_i) cmpb_q <= wdata_i;
  end

  assign cnt_o  = cnt_q;
  assign cmpa_o = cmpa_q;
  assign cmpb_o = cmpb_q;
endmodule

// File: rtl/dct_flag_cell.sv
module dct_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic lp_i,
  input  logic set_i,
  input  logic rd_sel_i,
  input  logic wr_sel_i,
  input  logic wbit_i,
  output logic flag_o,
  output logic arm_o
);
  logic flag_q, flag_d;
  logic arm_q, arm_d;
  logic clr_req;

  always_comb begin
    clr_req = wr_sel_i & ~wbit_i & arm_q;
    if (lp_i)         flag_d = 1'b0;
    else if (set_i)   flag_d = 1'b1;   // set beats clear
    else if (clr_req) flag_d = 1'b0;
    else              flag_d = flag_q;
  end

  always_comb begin
    if (lp_i)                     arm_d = 1'b0;
    else if (wr_sel_i)            arm_d = 1'b0;
    else if (rd_sel_i && flag_q)  arm_d = 1'b1;
    else                          arm_d = arm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
    end
  end

  assign flag_o = flag_q;
  assign arm_o  = arm_q;
endmodule

// File: rtl/dct_pin_ctrl.sv
module dct_pin_ctrl
  import dct_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lp_i,
  input  logic       ev_a_i,
  input  logic       ev_b_i,
  input  logic [1:0] act_a_i,
  input  logic [1:0] act_b_i,
  output logic       pin_o
);
  pin_act_e sel;
  logic     pin_q, pin_d, pin_en;

  always_comb begin
    sel = PIN_HOLD;
    if (!lp_i) begin
      if (ev_b_i && (pin_act_e'(act_b_i) != PIN_HOLD)) sel = pin_act_e'(act_b_i);
      else if (ev_a_i)                                 sel = pin_act_e'(act_a_i);
    end
  end

  always_comb begin
    pin_en = (sel != PIN_HOLD);
    unique case (sel)
      PIN_LOW:    pin_d = 1'b0;
      PIN_HIGH:   pin_d = 1'b1;
      PIN_TOGGLE: pin_d = ~pin_q;
      default:    pin_d = pin_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pin_q <= 1'b0;
    else if (pin_en) pin_q <= pin_d;
  end

  assign pin_o = pin_q;
endmodule

// File: rtl/dct_timer_csr.sv
module dct_timer_csr
  import dct_pkg::*;
(
  input  logic          clk,
  input  logic          arst_n,
  input  logic          lp_mode_i,
  input  logic          tick_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ext_cma_i,
  input  logic          ext_cmb_i,
  input  logic          ext_ovf_i,
  output logic [DW-1:0] rdata_o,
  output logic          cmp_pin_o
);
  logic rst_n;

  dct_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n)
  );

  reg_addr_e addr;
  logic wr_csr, rd_csr, wr_cnt, wr_cmpa, wr_cmpb;

  always_comb begin
    addr    = reg_addr_e'(addr_i);
    wr_csr  = wr_i & (addr == ADDR_CSR) & ~lp_mode_i;
    rd_csr  = rd_i & (addr == ADDR_CSR) & ~lp_mode_i;
    wr_cnt  = wr_i & (addr == ADDR_CNT);
    wr_cmpa = wr_i & (addr == ADDR_CMPA);
    wr_cmpb = wr_i & (addr == ADDR_CMPB);
  end

  logic [DW-1:0] cnt_v, cmpa_v, cmpb_v;
  logic          hit_ovf, hit_a, hit_b;

  dct_count_unit #(.W(DW), .CMP_INIT('1)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .wr_cnt_i  (wr_cnt),
    .wr_cmpa_i (wr_cmpa),
    .wr_cmpb_i (wr_cmpb),
    .wdata_i   (wdata_i),
    .cnt_o     (cnt_v),
    .cmpa_o    (cmpa_v),
    .cmpb_o    (cmpb_v),
    .hit_ovf_o (hit_ovf),
    .hit_a_o   (hit_a),
    .hit_b_o   (hit_b)
  );

  logic [NFLAG-1:0] flag_ev, flag_q, arm_q;

  always_comb begin
    flag_ev         = '0;
    flag_ev[FI_OVF] = hit_ovf | ext_ovf_i;
    flag_ev[FI_CMA] = hit_a   | ext_cma_i;
    flag_ev[FI_CMB] = hit_b   | ext_cmb_i;
  end

  for (genvar k = 0; k < NFLAG; k++) begin : g_flag
    dct_flag_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .lp_i     (lp_mode_i),
      .set_i    (flag_ev[k]),
      .rd_sel_i (rd_csr),
      .wr_sel_i (wr_csr),
      .wbit_i   (wdata_i[FLG_LSB+k]),
      .flag_o   (flag_q[k]),
      .arm_o    (arm_q[k])
    );
  end

  logic [OS_W-1:0] os_q, os_d;
  logic            os_en;

  always_comb begin
    os_en = wr_csr | lp_mode_i;
    if (lp_mode_i) os_d = '0;
    else           os_d = wdata_i[OS_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     os_q <= '0;
    else if (os_en) os_q <= os_d;
  end

  dct_pin_ctrl u_pin (
    .clk     (clk),
    .rst_n   (rst_n),
    .lp_i    (lp_mode_i),
    .ev_a_i  (flag_ev[FI_CMA]),
    .ev_b_i  (flag_ev[FI_CMB]),
    .act_a_i (os_q[1:0]),
    .act_b_i (os_q[3:2]),
    .pin_o   (cmp_pin_o)
  );

  logic [DW-1:0] csr_view;

  always_comb begin
    if (lp_mode_i) csr_view = CSR_RESET;
    else           csr_view = {flag_q[FI_CMB], flag_q[FI_CMA], flag_q[FI_OVF], 1'b1, os_q};
  end

  always_comb begin
    unique case (addr)
      ADDR_CSR:  rdata_o = csr_view;
      ADDR_CNT:  rdata_o = cnt_v;
      ADDR_CMPA: rdata_o = cmpa_v;
      default:   rdata_o = cmpb_v;
    endcase
  end
endmodule

// File: rtl/dct_timer_csr_chk.sv
module dct_timer_csr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       lp_i,
  input logic       wr_i,
  input logic [1:0] addr_i,
  input logic [7:0] wdata_i,
  input logic [2:0] ev_i,
  input logic [2:0] flag_i,
  input logic [2:0] arm_i,
  input logic [3:0] os_i,
  input logic [7:0] rdata_o
);
  a_r5_bit4_reads_one: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == 2'd0) |-> rdata_o[4]);

  a_r2_lp_idles: assert property (@(posedge clk) disable iff (!rst_n)
    lp_i |=> (flag_i == 3'b000 && os_i == 4'h0 && arm_i == 3'b000));

  a_r4_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (!lp_i && ev_i != 3'b000) |=> ((flag_i & $past(ev_i)) == $past(ev_i)));

  a_r6_unarmed_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !lp_i |=> ((flag_i & $past(flag_i & ~arm_i)) == $past(flag_i & ~arm_i)));

  a_r7_write_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_i == 2'd0) |=> (arm_i == 3'b000));

  a_r9_os_written: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_i == 2'd0 && !lp_i) |=> (os_i == $past(wdata_i[3:0])));
endmodule

bind dct_timer_csr dct_timer_csr_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .lp_i    (lp_mode_i),
  .wr_i    (wr_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .ev_i    (flag_ev),
  .flag_i  (flag_q),
  .arm_i   (arm_q),
  .os_i    (os_q),
  .rdata_o (rdata_o)
);

// File: tb/dct_timer_csr_bench.sv
`timescale 1ns/1ps
module dct_timer_csr_bench;
  logic       clk, arst_n, lp, tick, rd, wr;
  logic [1:0] addr;
  logic [7:0] wdata, rdata;
  logic       ea, eb, eo, pin;

  int n_chk = 0;
  int n_bad = 0;

  dct_timer_csr u_dct_timer_csr (
    .clk(clk), .arst_n(arst_n), .lp_mode_i(lp), .tick_i(tick),
    .rd_i(rd), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .ext_cma_i(ea), .ext_cmb_i(eb), .ext_ovf_i(eo),
    .rdata_o(rdata), .cmp_pin_o(pin)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // bench model
  logic [7:0] m_cnt, m_ca, m_cb;
  logic [2:0] m_flag, m_arm;   // [0] overflow, [1] A, [2] B
  logic [3:0] m_os;
  logic       m_pin;

  function automatic logic [7:0] exp_read(input logic [1:0] a, input logic l,
      input logic [7:0] c, input logic [7:0] ca, input logic [7:0] cb,
      input logic [2:0] f, input logic [3:0] o);
    case (a)
      2'd0:    return l ? 8'h10 : {f[2], f[1], f[0], 1'b1, o};
      2'd1:    return c;
      2'd2:    return ca;
      default: return cb;
    endcase
  endfunction

  function automatic logic apply_act(input logic [1:0] act, input logic p);
    case (act)
      2'b01:   return 1'b0;
      2'b10:   return 1'b1;
      2'b11:   return ~p;
      default: return p;
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic [7:0] act, input logic [7:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%02h expected 0x%02h", tag, what, act, expv);
    end
  endtask

  task automatic model_update();
    logic wcnt, adv, ho, ha, hb;
    logic [7:0] inc;
    logic [2:0] ev, nf, na;
    logic wcsr, rcsr;
    wcnt = wr && addr == 2'd1;
    adv  = tick && !wcnt;
    inc  = m_cnt + 8'd1;
    ho   = adv && m_cnt == 8'hFF;
    ha   = adv && inc == m_ca;
    hb   = adv && inc == m_cb;
    ev   = {eb | hb, ea | ha, eo | ho};
    wcsr = wr && addr == 2'd0 && !lp;
    rcsr = rd && addr == 2'd0 && !lp;
    if (!lp) begin
      if (ev[2] && m_os[3:2] != 2'b00) m_pin = apply_act(m_os[3:2], m_pin);
      else if (ev[1])                  m_pin = apply_act(m_os[1:0], m_pin);
    end
    nf = m_flag;
    na = m_arm;
    for (int k = 0; k < 3; k++) begin
      if (ev[k]) nf[k] = 1'b1;
      else if (wcsr && !wdata[5+k] && m_arm[k]) nf[k] = 1'b0;
    end
    if (wcsr) na = 3'b000;
    else if (rcsr) na = m_arm | m_flag;
    if (lp) begin
      nf = 3'b000; na = 3'b000; m_os = 4'h0;
    end else if (wcsr) m_os = wdata[3:0];
    m_flag = nf;
    m_arm  = na;
    if (wcnt) m_cnt = wdata;
    else if (adv) m_cnt = inc;
    if (wr && addr == 2'd2) m_ca = wdata;
    if (wr && addr == 2'd3) m_cb = wdata;
  endtask

  // one cycle: drive, check read data before the edge, check pin after it
  task automatic step(input string tag, input logic i_rd, input logic i_wr,
      input logic [1:0] i_addr, input logic [7:0] i_wd, input logic i_tick,
      input logic i_ea, input logic i_eb, input logic i_eo, input logic i_lp);
    rd = i_rd; wr = i_wr; addr = i_addr; wdata = i_wd; tick = i_tick;
    ea = i_ea; eb = i_eb; eo = i_eo; lp = i_lp;
    #1;
    check(tag, "rdata", rdata, exp_read(addr, lp, m_cnt, m_ca, m_cb, m_flag, m_os));
    model_update();
    @(posedge clk);
    #1;
    check("R10", "pin", {7'd0, pin}, {7'd0, m_pin});
    @(negedge clk);
  endtask

  task automatic rdc(input string tag, input logic [1:0] a);
    step(tag, 1'b1, 1'b0, a, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic wrc(input string tag, input logic [1:0] a, input logic [7:0] d);
    step(tag, 1'b0, 1'b1, a, d, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic idle(input string tag, input logic t);
    step(tag, 1'b0, 1'b0, 2'd0, 8'h00, t, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    arst_n = 1'b0; lp = 0; tick = 0; rd = 0; wr = 0; addr = 0; wdata = 0;
    ea = 0; eb = 0; eo = 0;
    m_cnt = 8'h00; m_ca = 8'hFF; m_cb = 8'hFF; m_flag = 0; m_arm = 0; m_os = 0; m_pin = 0;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state of every register and the pin
    for (int a = 0; a < 4; a++) rdc("R1", 2'(a));

    // R5: flag bits and bit 4 written as 1 do nothing; R9 os readback
    wrc("R5", 2'd0, 8'hE5);
    rdc("R9", 2'd0);
    check("R5", "csr literal", rdata, 8'h15);

    // R3 overflow on wrap, counter write R11
    wrc("R11", 2'd1, 8'hFE);
    idle("R3", 1'b1);
    idle("R3", 1'b1);
    rdc("R3", 2'd0);
    rdc("R11", 2'd1);

    // R4 compare hits with pin actions: A drives low, B drives high
    wrc("R9", 2'd0, 8'h09);
    wrc("R11", 2'd2, 8'h05);
    wrc("R11", 2'd3, 8'h07);
    wrc("R11", 2'd1, 8'h03);
    for (int i = 0; i < 5; i++) idle("R4", 1'b1);
    rdc("R4", 2'd0);

    // R6: unarmed write of 0 keeps flags; armed write clears
    wrc("R6", 2'd0, 8'hE9);
    wrc("R6", 2'd0, 8'h09);
    rdc("R6", 2'd0);
    wrc("R6", 2'd0, 8'h09);
    rdc("R6", 2'd0);
    check("R6", "cleared literal", rdata, 8'h19);

    // R7: write disarms even when it clears nothing
    step("R7", 0, 0, 2'd0, 8'h00, 0, 1, 0, 0, 0);
    rdc("R7", 2'd0);
    wrc("R7", 2'd0, 8'hE0);
    wrc("R7", 2'd0, 8'h00);
    rdc("R7", 2'd0);

    // R8: armed clear in the same cycle as a set event
    rdc("R8", 2'd0);
    step("R8", 0, 1, 2'd0, 8'h00, 0, 1, 0, 0, 0);
    rdc("R8", 2'd0);
    check("R8", "flag A literal", {7'd0, rdata[6]}, 8'h01);

    // R2: low power forces the reset view and ignores writes
    wrc("R2", 2'd0, 8'h0F);
    step("R2", 0, 0, 2'd0, 8'h00, 0, 1, 1, 1, 0);
    step("R2", 1, 1, 2'd0, 8'hFF, 0, 1, 1, 1, 1);
    step("R2", 1, 0, 2'd0, 8'h00, 0, 0, 0, 0, 1);
    rdc("R2", 2'd0);
    check("R2", "after lp literal", rdata, 8'h10);

    // R10 toggle on both channels, then both at once (B wins)
    wrc("R10", 2'd0, 8'h0F);
    step("R10", 0, 0, 2'd0, 8'h00, 0, 1, 0, 0, 0);
    step("R10", 0, 0, 2'd0, 8'h00, 0, 0, 1, 0, 0);
    wrc("R10", 2'd0, 8'h07);
    step("R10", 0, 0, 2'd0, 8'h00, 0, 1, 1, 0, 0);
    step("R10", 0, 0, 2'd0, 8'h00, 0, 1, 0, 0, 0);

    // R11: counter write in a tick cycle wins and raises no hit
    wrc("R11", 2'd2, 8'h41);
    wrc("R6", 2'd0, 8'h00);
    step("R11", 1, 0, 2'd0, 8'h00, 0, 0, 0, 0, 0);
    wrc("R6", 2'd0, 8'h00);
    step("R11", 0, 1, 2'd1, 8'h41, 1, 0, 0, 0, 0);
    rdc("R11", 2'd1);
    rdc("R11", 2'd0);

    // random phase
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step("R4", r[0], r[3:1] == 3'b000, r[5:4], 8'($urandom), r[7:6] != 2'b00,
           r[12:8] == 5'd0, r[17:13] == 5'd0, r[22:18] == 5'd0, r[28:23] == 6'd0);
    end

    summary();
    $finish;
  end
endmodule